// File: doc/BRIEF.md
# Idle-Framed Stream Receiver

This block sits after the lane decoder of a chip-to-chip serial link. Each cycle it may be handed one decoded 32-bit lane word, together with one control flag per byte. It sorts every word into one of four kinds:

- an idle filler, which is dropped;
- an opcode, whose two payload bytes go out on their own strobe-qualified port;
- a data word, which is split into two 16-bit core words;
- a malformed control word, which is dropped and reported with a one-cycle error pulse.

Opcodes and data share the same lane, and idle words mark the gaps between packets. The core side runs at twice the word rate, so a lane word must be followed by at least one cycle without a word. In that cycle the second half of a data word is sent out.

A counter gives the number of data words seen since the most recent idle word. Downstream logic compares it with the configured packet length.

Top module: `idle_frame_rx`

## Requirements
- R1: After reset, `core_vld`, `op_vld` and `proto_err` are low and `pkt_len` is zero.
- R2: A word with control flags 4'b1111 and bytes BC, BC, 1C, 1C (bits 31:24 down to 7:0) is an idle word. It produces no strobe, and `pkt_len` reads zero in the cycle after the edge that accepted it.
- R3: A word with control flags 4'b1100 and bytes 31:24 and 23:16 both FD is an opcode. In the cycle after the accepting edge, `op_vld` is high for one cycle and `op_code` equals bits 15:0 of the word.
- R4: A word with control flags 4'b0000 is data. `core_vld` is high in the two cycles after the accepting edge. `core_word` carries bits 31:16 in the first of those cycles and bits 15:0 in the second.
- R5: Any other word that has at least one control flag set raises `proto_err` for exactly one cycle, in the cycle after the accepting edge. It produces no other strobe and leaves `pkt_len` unchanged.
- R6: `pkt_len` rises by one for each data word, in the same cycle as that word's first half. Opcodes leave it unchanged, and it saturates at its all-ones value.
- R7: While `in_vld` is low, no new opcode, error or data output starts. Only the second half of a data word accepted earlier can still appear.
- R8: `in_vld` is never high on two consecutive clock edges. This is a usage rule that comes from the 2:1 rate ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the lane word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Qualifies `in_word` and `in_k` |
| in_word | input | 32 | Decoded lane word; bits 31:24 are the first character |
| in_k | input | 4 | Per-byte control flag; bit i belongs to byte i |
| op_vld | output | 1 | Opcode payload strobe |
| op_code | output | 16 | Opcode payload (lower two bytes of the word) |
| core_vld | output | 1 | Core word strobe |
| core_word | output | 16 | Unpacked core word |
| proto_err | output | 1 | Malformed control word pulse |
| pkt_len | output | 24 | Data words since the last idle word |

## Verification
Each result has a fixed timing:

- The opcode strobe, the error pulse, the first data half and the updated `pkt_len` all appear exactly one edge after the accepting edge.
- The second data half appears one edge after that.

The bench drives a word on a falling edge and withdraws it on the next falling edge. It samples the first-cycle results at that falling edge and the second half one falling edge later. Every sample is therefore taken half a clock away from the edge that produced it.

The sweep covers all sixteen control-flag patterns against idle-like, opcode-like and plain byte contents. Its expected kind for each word is derived only from the byte and flag encodings above. A reduced counter width lets the bench reach saturation.

// File: rtl/idle_rx_pkg.sv
package idle_rx_pkg;
   localparam logic [7:0] CH_FILL_A = 8'hBC;
   localparam logic [7:0] CH_FILL_B = 8'h1C;
   localparam logic [7:0] CH_OPMARK = 8'hFD;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_OPC  = 2'd1,
      WK_DATA = 2'd2,
      WK_BAD  = 2'd3
   } word_kind_t;
endpackage

// File: rtl/rx_char_match.sv
module rx_char_match #(
   parameter int NB = 4
) (
   input  logic [8*NB-1:0] word,
   input  logic [NB-1:0]   kf,
   input  logic [8*NB-1:0] pat,
   input  logic [NB-1:0]   kpat,
   input  logic [NB-1:0]   care,
   output logic            hit
);
   logic [NB-1:0] byte_ok;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign byte_ok[i] = !care[i] || (word[8*i +: 8] == pat[8*i +: 8]);
   end

   assign hit = (&byte_ok) && (kf == kpat);
endmodule

// File: rtl/rx_word_class.sv
module rx_word_class
   import idle_rx_pkg::*;
#(
   parameter int NB = 4
) (
   input  logic [8*NB-1:0] word,
   input  logic [NB-1:0]   kf,
   output word_kind_t      kind
);
   localparam int HALF = NB / 2;

   if (NB < 2 || (NB % 2) != 0) begin : g_bad_nb
      $error("rx_word_class: NB must be even and at least 2");
   end

   logic [8*NB-1:0] idle_pat, op_pat;
   logic [NB-1:0]   idle_k, op_k, op_care;
   logic            idle_hit, op_hit;

   for (genvar i = 0; i < NB; i++) begin : g_pat
      if (i >= HALF) begin : g_hi
         assign idle_pat[8*i +: 8] = CH_FILL_A;
         assign op_pat[8*i +: 8]   = CH_OPMARK;
         assign op_k[i]            = 1'b1;
         assign op_care[i]         = 1'b1;
      end else begin : g_lo
         assign idle_pat[8*i +: 8] = CH_FILL_B;
         assign op_pat[8*i +: 8]   = 8'h00;
         assign op_k[i]            = 1'b0;
         assign op_care[i]         = 1'b0;
      end
      assign idle_k[i] = 1'b1;
   end

   rx_char_match #(.NB(NB)) u_idle (
      .word(word), .kf(kf), .pat(idle_pat), .kpat(idle_k),
      .care(idle_k), .hit(idle_hit)
   );

   rx_char_match #(.NB(NB)) u_opc (
      .word(word), .kf(kf), .pat(op_pat), .kpat(op_k),
      .care(op_care), .hit(op_hit)
   );

   always_comb begin
      if (idle_hit)      kind = WK_IDLE;
      else if (op_hit)   kind = WK_OPC;
      else if (kf == '0) kind = WK_DATA;
      else               kind = WK_BAD;
   end
endmodule

// File: rtl/rx_halfword_split.sv
module rx_halfword_split #(
   parameter int LANE_W      = 32,
   parameter int CORE_W      = 16,
   parameter bit UPPER_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANE_W-1:0] word,
   output logic              out_vld,
   output logic [CORE_W-1:0] out_word
);
   if (LANE_W != 2 * CORE_W) begin : g_bad_w
      $error("rx_halfword_split: LANE_W must be twice CORE_W");
   end

   logic [CORE_W-1:0] first_h, second_h, hold;
   logic              pend;

   if (UPPER_FIRST) begin : g_upper
      assign first_h  = word[LANE_W-1 -: CORE_W];
      assign second_h = word[CORE_W-1:0];
   end else begin : g_lower
      assign first_h  = word[CORE_W-1:0];
      assign second_h = word[LANE_W-1 -: CORE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         hold     <= '0;
         out_vld  <= 1'b0;
         out_word <= '0;
      end else if (load) begin
         out_vld  <= 1'b1;
         out_word <= first_h;
         hold     <= second_h;
         pend     <= 1'b1;
      end else if (pend) begin
         out_vld  <= 1'b1;
         out_word <= hold;
         pend     <= 1'b0;
      end else begin
         out_vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_pkt_counter.sv
module rx_pkt_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("rx_pkt_counter: CNT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt <= '0;
      else if (clr)                      cnt <= '0;
      else if (inc && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/idle_frame_rx.sv
module idle_frame_rx
   import idle_rx_pkg::*;
#(
   parameter int LANE_BYTES  = 4,
   parameter int CORE_W      = 16,
   parameter int CNT_W       = 24,
   parameter bit UPPER_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [8*LANE_BYTES-1:0] in_word,
   input  logic [LANE_BYTES-1:0] in_k,
   output logic                  op_vld,
   output logic [CORE_W-1:0]     op_code,
   output logic                  core_vld,
   output logic [CORE_W-1:0]     core_word,
   output logic                  proto_err,
   output logic [CNT_W-1:0]      pkt_len
);
   localparam int LANE_W = 8 * LANE_BYTES;

   if (LANE_W != 2 * CORE_W) begin : g_bad_geom
      $error("idle_frame_rx: lane word must hold exactly two core words");
   end

   word_kind_t kind;
   logic       take_data, take_idle, take_op, take_bad;

   rx_word_class #(.NB(LANE_BYTES)) u_class (
      .word(in_word), .kf(in_k), .kind(kind)
   );

   assign take_data = in_vld && (kind == WK_DATA);
   assign take_idle = in_vld && (kind == WK_IDLE);
   assign take_op   = in_vld && (kind == WK_OPC);
   assign take_bad  = in_vld && (kind == WK_BAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_vld    <= 1'b0;
         op_code   <= '0;
         proto_err <= 1'b0;
      end else begin
         op_vld    <= take_op;
         proto_err <= take_bad;
         if (take_op) op_code <= in_word[CORE_W-1:0];
      end
   end

   rx_halfword_split #(
      .LANE_W(LANE_W), .CORE_W(CORE_W), .UPPER_FIRST(UPPER_FIRST)
   ) u_split (
      .clk(clk), .rst_n(rst_n), .load(take_data), .word(in_word),
      .out_vld(core_vld), .out_word(core_word)
   );

   rx_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(take_idle), .inc(take_data), .cnt(pkt_len)
   );

   AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> !in_vld); // R8
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      take_idle |=> (pkt_len == '0)); // R2
   AST_OP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |-> !proto_err); // R3
   AST_DATA_TWO_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      take_data |=> core_vld ##1 core_vld); // R4
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !proto_err); // R5
   AST_QUIET_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!op_vld && !proto_err)); // R7
   AST_LEN_STABLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (take_op || take_bad) |=> $stable(pkt_len)); // R6
endmodule

// File: tb/tb_idle_frame_rx.sv
module tb_idle_frame_rx;
   localparam int CW = 4;
   localparam logic [CW-1:0] LMAX = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_word = '0;
   logic [3:0]  in_k = '0;
   logic        op_vld, core_vld, proto_err;
   logic [15:0] op_code, core_word;
   logic [CW-1:0] pkt_len;

   int checks = 0;
   int failures = 0;
   logic [CW-1:0] exp_len = '0;

   always #10 clk = ~clk;

   idle_frame_rx #(.LANE_BYTES(4), .CORE_W(16), .CNT_W(CW), .UPPER_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word), .in_k(in_k),
      .op_vld(op_vld), .op_code(op_code), .core_vld(core_vld),
      .core_word(core_word), .proto_err(proto_err), .pkt_len(pkt_len)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input logic [3:0] k);
      bit is_idle, is_op, is_data, is_err;
      is_idle = (w == 32'hBCBC_1C1C) && (k == 4'b1111);
      is_op   = (w[31:16] == 16'hFDFD) && (k == 4'b1100);
      is_data = (k == 4'b0000);
      is_err  = !is_idle && !is_op && !is_data;
      if (is_idle) exp_len = '0;
      else if (is_data && exp_len != LMAX) exp_len = exp_len + 1'b1;
      @(negedge clk);
      in_vld = 1'b1; in_word = w; in_k = k;
      @(negedge clk);
      in_vld = 1'b0;
      chk(op_vld == is_op, "R3 op_vld", 32'(op_vld), 32'(is_op));
      if (is_op) chk(op_code == w[15:0], "R3 op_code", 32'(op_code), 32'(w[15:0]));
      chk(proto_err == is_err, "R5 proto_err", 32'(proto_err), 32'(is_err));
      chk(core_vld == is_data, "R4 core_vld first", 32'(core_vld), 32'(is_data));
      if (is_data) chk(core_word == w[31:16], "R4 upper half", 32'(core_word), 32'(w[31:16]));
      chk(pkt_len == exp_len, is_idle ? "R2 pkt_len clear" : "R6 pkt_len",
          32'(pkt_len), 32'(exp_len));
      @(negedge clk);
      chk(core_vld == is_data, "R4 core_vld second", 32'(core_vld), 32'(is_data));
      if (is_data) chk(core_word == w[15:0], "R4 lower half", 32'(core_word), 32'(w[15:0]));
      chk(!op_vld && !proto_err, "R5 single-cycle strobes", 32'({op_vld, proto_err}), 32'h0);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!op_vld && !core_vld && !proto_err, "R1 strobes after reset",
          32'({op_vld, core_vld, proto_err}), 32'h0);
      chk(pkt_len == '0, "R1 pkt_len after reset", 32'(pkt_len), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!op_vld && !core_vld && !proto_err && pkt_len == '0, "R1 idle after release",
          32'({op_vld, core_vld, proto_err}), 32'h0);

      // every control-flag pattern against four byte contents
      for (int k = 0; k < 16; k++) begin
         send(32'hBCBC_1C1C, 4'(k));
         send(32'hFDFD_0000 | 32'(k * 16'h1111), 4'(k));
         send(32'hBCBC_1C1D, 4'(k));
         send(32'h1234_5678 ^ 32'(k << 20), 4'(k));
      end

      // opcode payload sweep interleaved with data
      for (int p = 0; p < 16; p++) begin
         send(32'hFDFD_0000 | 32'(p * 16'h0F01), 4'b1100);
         send(32'(p) * 32'h0101_0101, 4'b0000);
      end

      // counter saturation: idle then more than 15 data words
      send(32'hBCBC_1C1C, 4'b1111);
      for (int d = 0; d < 20; d++) send(32'hA5A5_0000 + 32'(d), 4'b0000);
      chk(pkt_len == LMAX, "R6 saturation", 32'(pkt_len), 32'(LMAX));
      send(32'hFDFD_BEEF, 4'b1100);
      send(32'hBCBC_1C1C, 4'b1111);

      // quiet lane: nothing starts without in_vld
      for (int q = 0; q < 4; q++) begin
         @(negedge clk);
         in_word = 32'hFDFD_0000 + 32'(q);
         in_k = 4'b1100;
         chk(!op_vld && !core_vld && !proto_err, "R7 no output while invalid",
             32'({op_vld, core_vld, proto_err}), 32'h0);
      end
      chk(pkt_len == '0, "R7 pkt_len held", 32'(pkt_len), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule